// File: doc/BRIEF.md
# Packed Half-Precision Compare Unit

This unit takes two vectors of 16-bit IEEE half-precision numbers and compares them lane by lane. Each lane yields one bit, and the bits together form a result mask. An 8-bit immediate selects the comparison. Only its low five bits are used, which gives 32 predicate codes. Each code fixes three things: which ordered relations report true, what an unordered pair (a pair with a NaN) reports, and whether a quiet NaN counts as an invalid operation.

The caller can gate lanes with a write mask, can broadcast the lowest element of the second operand to every lane, and selects a vector length of 128, 256 or 512 bits. The unit also raises an invalid flag and a denormal flag. At the 512-bit length these flags can be suppressed. The unit has no state machine: one input strobe is followed, one clock later, by one registered result.

Top module: `hcmp_unit`

## Requirements
- R1: Only `imm[4:0]` selects the predicate. Changing `imm[7:5]` alters neither the mask nor the flags.
- R2: For a pair with no NaN, codes 0..15 give: 0 EQ, 1 LT, 2 LE, 3 false, 4 NE, 5 not-LT, 6 not-LE, 7 true, 8 EQ, 9 not-GE, 10 not-GT, 11 false, 12 NE, 13 GE, 14 GT, 15 true. Here +0 equals -0, and subnormals compare by their exact value. Code c+16 gives the same result as code c.
- R3: A NaN has exponent 31 and a nonzero mantissa. If either input is NaN, codes 3,4,5,6,8,9,10,15 (and the same codes +16) give 1, and all other codes give 0.
- R4: A signaling NaN has mantissa bit 9 clear. For an evaluated lane, a signaling NaN input always raises invalid. A quiet NaN input raises invalid only for signaling codes. The signaling codes are {1,2,5,6,9,10,13,14} and {16,19,20,23,24,27,28,31}.
- R5: `vlen` 0 selects 8 lanes (128 bits), 1 selects 16 lanes (256 bits), and 2 or 3 select 32 lanes (512 bits). Lane j uses bits [16j+15:16j].
- R6: When `use_wmask` is 1, a lane whose `wmask` bit is 0 yields 0 and adds nothing to the flags. When `use_wmask` is 0, every active lane is evaluated.
- R7: When `bcast` is 1, element 0 of `src_b` is compared against every lane of `src_a`.
- R8: Mask bits at and above the active lane count are 0.
- R9: `out_denormal` is 1 when any evaluated lane has an input with exponent 0 and a nonzero mantissa.
- R10: `suppress_exc` forces both flags to 0 only when `vlen` selects 512 bits. At other lengths it has no effect.
- R11: Mask and flags are registered on the edge where `in_valid` is 1, and `out_valid` is high for the following cycle. Without a strobe, the outputs hold their values. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| imm | input | 8 | Predicate immediate |
| vlen | input | 2 | Vector length select |
| use_wmask | input | 1 | Enable write mask |
| wmask | input | 32 | Per-lane write mask |
| bcast | input | 1 | Broadcast element 0 of src_b |
| suppress_exc | input | 1 | Suppress flags (512-bit only) |
| src_a | input | 512 | First operand vector |
| src_b | input | 512 | Second operand vector |
| out_valid | output | 1 | Result strobe |
| out_mask | output | 32 | Result mask |
| out_invalid | output | 1 | Invalid-operation flag |
| out_denormal | output | 1 | Denormal-input flag |

## Verification
The assertions check four rules on every cycle:
- upper mask bits are cleared for short vectors;
- masked-off lanes never report true;
- flags are suppressed at 512 bits;
- the result registers hold between strobes.

Only the bench scenarios can show the predicate semantics: the ordered and unordered results of all 32 codes, the quiet and signaling invalid rules, the broadcast source, and the value ordering of zeros and subnormals. The bench checks these against a reference model built on real-number arithmetic.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;
    localparam int EXP_W  = 5;
    localparam int MAN_W  = 10;
    localparam int ELEM_W = 1 + EXP_W + MAN_W;

    // Decoded predicate: which outcome classes report true, and quiet-NaN policy
    typedef struct packed {
        logic on_unord;
        logic on_gt;
        logic on_eq;
        logic on_lt;
        logic signaling;
    } pred_sel_t;
endpackage

// File: rtl/hcmp_pred_decode.sv
module hcmp_pred_decode
    import hcmp_pkg::*;
(
    input  logic [7:0] imm,
    output pred_sel_t  sel
);
    logic [3:0] rel;   // {unord, gt, eq, lt}

    always_comb begin
        unique case (imm[3:0])
            4'd0:  rel = 4'b0010;
            4'd1:  rel = 4'b0001;
            4'd2:  rel = 4'b0011;
            4'd3:  rel = 4'b1000;
            4'd4:  rel = 4'b1101;
            4'd5:  rel = 4'b1110;
            4'd6:  rel = 4'b1100;
            4'd7:  rel = 4'b0111;
            4'd8:  rel = 4'b1010;
            4'd9:  rel = 4'b1001;
            4'd10: rel = 4'b1011;
            4'd11: rel = 4'b0000;
            4'd12: rel = 4'b0101;
            4'd13: rel = 4'b0110;
            4'd14: rel = 4'b0100;
            default: rel = 4'b1111;
        endcase
    end

    assign sel.on_unord  = rel[3];
    assign sel.on_gt     = rel[2];
    assign sel.on_eq     = rel[1];
    assign sel.on_lt     = rel[0];
    // Base signaling sense for codes where the low two bits differ; bit 4 flips it
    assign sel.signaling = (imm[1] ^ imm[0]) ^ imm[4];
endmodule

// File: rtl/hcmp_lane.sv
module hcmp_lane
    import hcmp_pkg::*;
(
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    input  pred_sel_t         sel,
    input  logic              active,
    output logic              hit,
    output logic              inv,
    output logic              den
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic a_nan, b_nan, a_snan, b_snan, a_sub, b_sub, both_zero, unord;
    logic lt, eq, gt, mag_lt;

    assign a_nan  = (&a[MAG_W-1:MAN_W]) && (|a[MAN_W-1:0]);
    assign b_nan  = (&b[MAG_W-1:MAN_W]) && (|b[MAN_W-1:0]);
    assign a_snan = a_nan && !a[MAN_W-1];
    assign b_snan = b_nan && !b[MAN_W-1];
    assign a_sub  = (~|a[MAG_W-1:MAN_W]) && (|a[MAN_W-1:0]);
    assign b_sub  = (~|b[MAG_W-1:MAN_W]) && (|b[MAN_W-1:0]);
    assign both_zero = (~|a[MAG_W-1:0]) && (~|b[MAG_W-1:0]);
    assign unord  = a_nan || b_nan;
    assign mag_lt = a[MAG_W-1:0] < b[MAG_W-1:0];

    always_comb begin
        lt = 1'b0;
        eq = 1'b0;
        gt = 1'b0;
        if (both_zero) begin
            eq = 1'b1;
        end else if (a[ELEM_W-1] != b[ELEM_W-1]) begin
            lt = a[ELEM_W-1];
            gt = b[ELEM_W-1];
        end else if (a[MAG_W-1:0] == b[MAG_W-1:0]) begin
            eq = 1'b1;
        end else begin
            lt = a[ELEM_W-1] ? !mag_lt : mag_lt;
            gt = !lt;
        end
    end

    assign hit = active && (unord ? sel.on_unord
                                  : ((lt && sel.on_lt) || (eq && sel.on_eq) || (gt && sel.on_gt)));
    assign inv = active && (a_snan || b_snan || (sel.signaling && unord));
    assign den = active && (a_sub || b_sub);
endmodule

// File: rtl/hcmp_unit.sv
module hcmp_unit
    import hcmp_pkg::*;
#(
    parameter int NUM_LANES = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  imm,
    input  logic [1:0]                  vlen,
    input  logic                        use_wmask,
    input  logic [NUM_LANES-1:0]        wmask,
    input  logic                        bcast,
    input  logic                        suppress_exc,
    input  logic [NUM_LANES*16-1:0]     src_a,
    input  logic [NUM_LANES*16-1:0]     src_b,
    output logic                        out_valid,
    output logic [NUM_LANES-1:0]        out_mask,
    output logic                        out_invalid,
    output logic                        out_denormal
);
    localparam int Q_LANES = NUM_LANES / 4;
    localparam int H_LANES = NUM_LANES / 2;
    localparam int CNT_W   = $clog2(NUM_LANES + 1);

    pred_sel_t             sel;
    logic [CNT_W-1:0]      lane_cnt;
    logic [NUM_LANES-1:0]  hit, inv, den;
    logic                  quiet_exc;

    hcmp_pred_decode u_dec (.imm(imm), .sel(sel));

    always_comb begin
        unique case (vlen)
            2'd0:    lane_cnt = CNT_W'(Q_LANES);
            2'd1:    lane_cnt = CNT_W'(H_LANES);
            default: lane_cnt = CNT_W'(NUM_LANES);
        endcase
    end

    assign quiet_exc = suppress_exc && vlen[1];

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        logic [ELEM_W-1:0] b_el;
        logic              lane_on;
        assign b_el    = bcast ? src_b[ELEM_W-1:0] : src_b[j*ELEM_W +: ELEM_W];
        assign lane_on = (CNT_W'(j) < lane_cnt) && (!use_wmask || wmask[j]);
        hcmp_lane u_lane (
            .a      (src_a[j*ELEM_W +: ELEM_W]),
            .b      (b_el),
            .sel    (sel),
            .active (lane_on),
            .hit    (hit[j]),
            .inv    (inv[j]),
            .den    (den[j])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_invalid  <= 1'b0;
            out_denormal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask     <= hit;
                out_invalid  <= (|inv) && !quiet_exc;
                out_denormal <= (|den) && !quiet_exc;
            end
        end
    end

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(vlen) == 2'd0) |-> (out_mask[NUM_LANES-1:Q_LANES] == '0));

    p_wmask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(use_wmask)) |-> ((out_mask & ~$past(wmask)) == '0));

    p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(suppress_exc) && $past(vlen[1])) |-> (!out_invalid && !out_denormal));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_mask) && $stable(out_invalid) && $stable(out_denormal)));

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: tb/hcmp_unit_tb.sv
`timescale 1ns/1ps
module hcmp_unit_tb;
    localparam int NL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    imm = '0;
    logic [1:0]    vlen = '0;
    logic          use_wmask = 1'b0;
    logic [NL-1:0] wmask = '0;
    logic          bcast = 1'b0;
    logic          suppress_exc = 1'b0;
    logic [NL*16-1:0] src_a = '0;
    logic [NL*16-1:0] src_b = '0;
    logic          out_valid;
    logic [NL-1:0] out_mask;
    logic          out_invalid, out_denormal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hcmp_unit #(.NUM_LANES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm(imm), .vlen(vlen),
        .use_wmask(use_wmask), .wmask(wmask), .bcast(bcast), .suppress_exc(suppress_exc),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_mask(out_mask),
        .out_invalid(out_invalid), .out_denormal(out_denormal)
    );

    logic [15:0] specials [14] = '{16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7E00,
                                   16'h7D00, 16'hFD01, 16'h0001, 16'h8001, 16'h03FF,
                                   16'h3C00, 16'hBC00, 16'h7BFF, 16'h0400};

    function automatic bit is_nan(input logic [15:0] h);
        return (h[14:10] == 5'h1F) && (h[9:0] != 0);
    endfunction

    function automatic bit is_sub(input logic [15:0] h);
        return (h[14:10] == 5'h00) && (h[9:0] != 0);
    endfunction

    function automatic real to_real(input logic [15:0] h);
        real v;
        int  e;
        e = int'(h[14:10]);
        if (e == 31) v = 1.0e12;
        else if (e == 0) v = real'(h[9:0]) / 1024.0;
        else v = 1.0 + real'(h[9:0]) / 1024.0;
        if (e != 31) begin
            if (e == 0) e = 1;
            for (int k = 0; k < 15 - e; k++) v = v / 2.0;
            for (int k = 0; k < e - 15; k++) v = v * 2.0;
        end
        return h[15] ? -v : v;
    endfunction

    function automatic bit ref_hit(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b);
        real x, y;
        if (is_nan(a) || is_nan(b))
            return c[3:0] inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd15};
        x = to_real(a);
        y = to_real(b);
        case (c[3:0])
            4'd0, 4'd8:   return x == y;
            4'd1, 4'd9:   return x < y;
            4'd2, 4'd10:  return x <= y;
            4'd4, 4'd12:  return x != y;
            4'd5, 4'd13:  return x >= y;
            4'd6, 4'd14:  return x > y;
            4'd7, 4'd15:  return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

    function automatic bit ref_sig(input logic [4:0] c);
        return (c[3:0] inside {4'd1, 4'd2, 4'd5, 4'd6, 4'd9, 4'd10, 4'd13, 4'd14}) ^ c[4];
    endfunction

    logic [NL-1:0] exp_mask;
    logic          exp_inv, exp_den;

    task automatic compute_ref();
        int n;
        logic [15:0] a, b;
        n = (vlen == 2'd0) ? 8 : (vlen == 2'd1) ? 16 : 32;
        exp_mask = '0;
        exp_inv = 1'b0;
        exp_den = 1'b0;
        for (int j = 0; j < n; j++) begin
            if (!use_wmask || wmask[j]) begin
                a = src_a[j*16 +: 16];
                b = bcast ? src_b[15:0] : src_b[j*16 +: 16];
                exp_mask[j] = ref_hit(imm[4:0], a, b);
                if ((is_nan(a) && !a[9]) || (is_nan(b) && !b[9]) ||
                    (ref_sig(imm[4:0]) && (is_nan(a) || is_nan(b))))
                    exp_inv = 1'b1;
                if (is_sub(a) || is_sub(b)) exp_den = 1'b1;
            end
        end
        if (suppress_exc && vlen[1]) begin
            exp_inv = 1'b0;
            exp_den = 1'b0;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill_vectors();
        for (int j = 0; j < NL; j++) begin
            src_a[j*16 +: 16] = ($urandom % 2) ? specials[$urandom % 14] : 16'($urandom);
            src_b[j*16 +: 16] = ($urandom % 2) ? specials[$urandom % 14] : 16'($urandom);
        end
    endtask

    // Drive at negedge, strobe across one posedge, sample at the next negedge
    task automatic strobe_and_check(input string tag);
        compute_ref();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid R11"}, 32'(out_valid), 32'd1);
        check({tag, " mask"}, 32'(out_mask), 32'(exp_mask));
        check({tag, " invalid R4"}, 32'(out_invalid), 32'(exp_inv));
        check({tag, " denormal R9"}, 32'(out_denormal), 32'(exp_den));
    endtask

    task automatic t_reset();
        check("reset R11 valid", 32'(out_valid), 32'd0);
        check("reset R11 mask", 32'(out_mask), 32'd0);
        check("reset R11 flags", {30'd0, out_invalid, out_denormal}, 32'd0);
    endtask

    task automatic t_all_preds();
        vlen = 2'd2; use_wmask = 1'b0; bcast = 1'b0; suppress_exc = 1'b0;
        for (int rep = 0; rep < 4; rep++) begin
            for (int c = 0; c < 32; c++) begin
                fill_vectors();
                imm = {3'b000, 5'(c)};
                strobe_and_check("R2 R3 sweep");
            end
        end
    endtask

    task automatic t_upper_imm();
        logic [NL-1:0] m0;
        vlen = 2'd2;
        for (int c = 0; c < 32; c += 3) begin
            fill_vectors();
            imm = {3'b000, 5'(c)};
            strobe_and_check("R1 base");
            m0 = out_mask;
            imm = {3'b101, 5'(c)};
            strobe_and_check("R1 upper bits");
            check("R1 same mask", 32'(out_mask), 32'(m0));
        end
    endtask

    task automatic t_zero_sub();
        vlen = 2'd0;
        src_a = '0;
        src_b = '0;
        src_a[15:0] = 16'h8000; src_b[15:0] = 16'h0000;
        src_a[31:16] = 16'h0001; src_b[31:16] = 16'h0002;
        src_a[47:32] = 16'h8001; src_b[47:32] = 16'h0001;
        src_a[63:48] = 16'h03FF; src_b[63:48] = 16'h0400;
        imm = 8'd0;
        strobe_and_check("R2 zeros eq");
        check("R2 -0 == +0", 32'(out_mask[0]), 32'd1);
        imm = 8'd1;
        strobe_and_check("R2 subnormal lt");
        check("R2 subnormal order", 32'(out_mask[3:1]), 32'b111);
    endtask

    task automatic t_vlen();
        use_wmask = 1'b0; bcast = 1'b0;
        for (int v = 0; v < 4; v++) begin
            fill_vectors();
            vlen = 2'(v);
            imm = 8'd15;
            strobe_and_check("R5 R8 length");
            if (v == 0) check("R8 upper zero 128", 32'(out_mask[31:8]), 32'd0);
            if (v == 1) check("R5 16 lanes true", 32'(out_mask), 32'h0000FFFF);
        end
    endtask

    task automatic t_wmask();
        vlen = 2'd2;
        fill_vectors();
        use_wmask = 1'b1;
        wmask = 32'hA5C3_0F0F;
        imm = 8'd15;
        strobe_and_check("R6 mask true");
        check("R6 gated", 32'(out_mask), 32'hA5C3_0F0F);
        imm = 8'd4;
        strobe_and_check("R6 mask neq");
        src_a[15:0] = 16'h7D00;
        wmask[0] = 1'b0;
        imm = 8'd0;
        strobe_and_check("R6 masked snan");
        use_wmask = 1'b0;
    endtask

    task automatic t_bcast();
        vlen = 2'd2; bcast = 1'b1;
        fill_vectors();
        src_b[15:0] = 16'h3C00;
        for (int j = 0; j < NL; j++) src_a[j*16 +: 16] = (j % 2) ? 16'h3C00 : 16'h4000;
        imm = 8'd0;
        strobe_and_check("R7 broadcast");
        check("R7 eq pattern", 32'(out_mask), 32'hAAAA_AAAA);
        imm = 8'd14;
        fill_vectors();
        strobe_and_check("R7 broadcast random");
        bcast = 1'b0;
    endtask

    task automatic t_suppress();
        fill_vectors();
        src_a[15:0] = 16'h7D00;
        src_b[15:0] = 16'h0001;
        imm = 8'd1;
        suppress_exc = 1'b1;
        vlen = 2'd2;
        strobe_and_check("R10 512 suppressed");
        check("R10 flags off", {30'd0, out_invalid, out_denormal}, 32'd0);
        vlen = 2'd1;
        strobe_and_check("R10 256 not suppressed");
        check("R10 flags on", {30'd0, out_invalid, out_denormal}, 32'd3);
        suppress_exc = 1'b0;
    endtask

    task automatic t_hold();
        logic [NL-1:0] m0;
        logic i0, d0;
        vlen = 2'd2;
        fill_vectors();
        imm = 8'd2;
        strobe_and_check("R11 load");
        m0 = out_mask; i0 = out_invalid; d0 = out_denormal;
        fill_vectors();
        imm = 8'd15;
        repeat (3) @(negedge clk);
        check("R11 no strobe valid", 32'(out_valid), 32'd0);
        check("R11 hold mask", 32'(out_mask), 32'(m0));
        check("R11 hold flags", {30'd0, out_invalid, out_denormal}, {30'd0, i0, d0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_preds();
        t_upper_imm();
        t_zero_sub();
        t_vlen();
        t_wmask();
        t_bcast();
        t_suppress();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule